// File: doc/BRIEF.md
# Digital Delay-Lock Loop Controller

This block is the digital control loop of a delay-locked loop. On each cycle where the phase detector flags a valid sample, the block takes a signed binary error. That error is proportional to the phase and frequency difference between the reference and feedback clocks. The block turns the error into a bounded signed step and adds the step to a 9-bit unsigned delay code. The code drives the local delay chain so that the feedback edge moves toward the reference edge. A positive error means the feedback leads, so the delay grows.

A second copy of the code goes to a companion delay element on a control bus. That bus changes only when the user pulses a latch strobe and keeps its value between strobes. A hold input freezes the code at its present value; when hold is released, updates resume from the frozen code. A lock detector watches the size of the error and raises a lock flag once the loop has settled. It drops the flag when the error stays large, and it keeps counting while the loop is held. A synchronous active-low reset puts the loop back to mid-scale.

Top module: `dll_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `delay_code` becomes 256, `ctrl_bus` becomes 256 and `locked` becomes 0.
- R2: On a cycle with `pd_valid` high and `hold` low, `delay_code` becomes the old code plus the step. `pd_err` is read as an 8-bit two's complement value, and the step is that value clamped to the range -8 to +8.
- R3: The code saturates: a sum above 511 gives 511 and a sum below 0 gives 0, with no wraparound.
- R4: On a cycle with `pd_valid` low, `delay_code` keeps its value whatever `pd_err` carries.
- R5: On a cycle with `hold` high, `delay_code` keeps its value even when `pd_valid` is high. After `hold` falls, updates continue from the held code.
- R6: `ctrl_bus` changes only at an edge where `bus_strobe` is high. There it takes the value that `delay_code` holds after that edge.
- R7: When `bus_strobe` is high in the same cycle as an update (R2), `ctrl_bus` captures the newly computed code, not the old one.
- R8: `locked` rises at the edge of the 16th consecutive valid sample with an absolute error of 1 or less. A valid sample with a larger absolute error restarts the count. Cycles without a valid sample neither count nor restart.
- R9: `locked` falls at the edge of the 4th consecutive valid sample with an absolute error above 4. A valid sample with an absolute error of 4 or less restarts that count.
- R10: The lock counting of R8 and R9 continues while `hold` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_valid | input | 1 | Phase detector sample valid |
| pd_err | input | 8 | Signed phase/frequency error (two's complement) |
| hold | input | 1 | Freeze the delay code |
| bus_strobe | input | 1 | Latch the code onto the control bus |
| delay_code | output | 9 | Live code to the local delay chain |
| ctrl_bus | output | 9 | Latched code for the companion delay element |
| locked | output | 1 | Loop lock indication |

## Verification
Two functions can fall in the same cycle: the latch strobe and a code update. The bench provokes this by pulsing `bus_strobe` in the same cycle as a valid, unheld error sample. The bus must then show the freshly computed code, not the code that stood before the edge. Strobes are also driven during hold and on idle cycles, where the bus must take the unchanged code. A third overlap is hold with lock tracking: large errors are fed while the code is frozen, and the lock flag must still drop on time while the code stays put.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;

    parameter int CODE_W   = 9;
    parameter int ERR_W    = 8;
    parameter int MAX_STEP = 8;

    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int CODE_MID = 1 << (CODE_W - 1);
    localparam int SUM_W    = CODE_W + 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ERR_W-1:0]  err_t;
    typedef logic [ERR_W:0]    mag_t;

    typedef struct packed {
        logic valid;
        err_t err;
    } pd_sample_t;

    // magnitude of a two's complement error, one bit wider so -2^(W-1) fits
    function automatic mag_t err_mag(input err_t e);
        mag_t ext;
        ext = {e[ERR_W-1], e};
        return e[ERR_W-1] ? mag_t'(-ext) : ext;
    endfunction

    // error clamped to +/- MAX_STEP, still two's complement
    function automatic err_t clamp_step(input err_t e);
        if (!e[ERR_W-1] && (err_mag(e) > mag_t'(MAX_STEP)))
            return err_t'(MAX_STEP);
        if (e[ERR_W-1] && (err_mag(e) > mag_t'(MAX_STEP)))
            return err_t'(-MAX_STEP);
        return e;
    endfunction

endpackage

// File: rtl/dll_step_alu.sv
module dll_step_alu
    import dll_ctrl_pkg::*;
(
    input  code_t cur_code,
    input  err_t  err,
    output code_t next_code
);
    logic [SUM_W-1:0] code_ext;
    logic [SUM_W-1:0] step_ext;
    logic [SUM_W-1:0] sum;
    err_t             step;

    always_comb begin
        step     = clamp_step(err);
        code_ext = {2'b00, cur_code};
        step_ext = {{(SUM_W-ERR_W){step[ERR_W-1]}}, step};
        sum      = code_ext + step_ext;
        if (sum[SUM_W-1])
            next_code = '0;
        else if (sum > SUM_W'(CODE_MAX))
            next_code = code_t'(CODE_MAX);
        else
            next_code = sum[CODE_W-1:0];
    end
endmodule

// File: rtl/dll_lock_det.sv
module dll_lock_det
    import dll_ctrl_pkg::*;
#(
    parameter int ACQ_N    = 16,
    parameter int ACQ_TOL  = 1,
    parameter int LOSS_N   = 4,
    parameter int LOSS_TOL = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pd_sample_t smp,
    output logic       locked
);
    localparam int ACQ_CW  = $clog2(ACQ_N + 1);
    localparam int LOSS_CW = $clog2(LOSS_N + 1);

    logic [ACQ_CW-1:0]  near_cnt;
    logic [LOSS_CW-1:0] far_cnt;
    mag_t               mag;
    logic               is_near;
    logic               is_far;

    always_comb begin
        mag     = err_mag(smp.err);
        is_near = (mag <= mag_t'(ACQ_TOL));
        is_far  = (mag > mag_t'(LOSS_TOL));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            near_cnt <= '0;
            far_cnt  <= '0;
            locked   <= 1'b0;
        end else if (smp.valid) begin
            if (is_near) begin
                if (near_cnt == ACQ_CW'(ACQ_N - 1))
                    locked <= 1'b1;
                else
                    near_cnt <= near_cnt + 1'b1;
            end else begin
                near_cnt <= '0;
            end
            if (is_far) begin
                if (far_cnt == LOSS_CW'(LOSS_N - 1))
                    locked <= 1'b0;
                else
                    far_cnt <= far_cnt + 1'b1;
            end else begin
                far_cnt <= '0;
            end
        end
    end

    // R8: lock can only rise on a small-error valid sample
    assert_lock_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(smp.valid && (err_mag(smp.err) <= mag_t'(ACQ_TOL))));

    // R9: lock can only fall (outside reset) on a large-error valid sample
    assert_lock_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(locked) && $past(rst_n)) |-> $past(smp.valid && (err_mag(smp.err) > mag_t'(LOSS_TOL))));
endmodule

// File: rtl/dll_bus_latch.sv
module dll_bus_latch
    import dll_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe,
    input  code_t code_d,
    output code_t bus
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus <= code_t'(CODE_MID);
        else if (strobe)
            bus <= code_d;
    end

    // R6: bus steady without a strobe
    assert_bus_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(bus));
endmodule

// File: rtl/dll_ctrl.sv
module dll_ctrl
    import dll_ctrl_pkg::*;
#(
    parameter int ACQ_N    = 16,
    parameter int ACQ_TOL  = 1,
    parameter int LOSS_N   = 4,
    parameter int LOSS_TOL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_valid,
    input  logic [ERR_W-1:0]  pd_err,
    input  logic              hold,
    input  logic              bus_strobe,
    output logic [CODE_W-1:0] delay_code,
    output logic [CODE_W-1:0] ctrl_bus,
    output logic              locked
);
    pd_sample_t smp;
    code_t      code_q;
    code_t      alu_code;
    code_t      code_d;
    logic       do_update;

    assign smp       = '{valid: pd_valid, err: pd_err};
    assign do_update = smp.valid && !hold;

    dll_step_alu u_alu (
        .cur_code (code_q),
        .err      (smp.err),
        .next_code(alu_code)
    );

    always_comb code_d = do_update ? alu_code : code_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= code_t'(CODE_MID);
        else
            code_q <= code_d;
    end

    dll_bus_latch u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(bus_strobe),
        .code_d(code_d),
        .bus   (ctrl_bus)
    );

    dll_lock_det #(
        .ACQ_N   (ACQ_N),
        .ACQ_TOL (ACQ_TOL),
        .LOSS_N  (LOSS_N),
        .LOSS_TOL(LOSS_TOL)
    ) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp),
        .locked(locked)
    );

    assign delay_code = code_q;

    // R4: no valid sample, no code change
    assert_idle_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_valid |=> $stable(delay_code));

    // R5: hold freezes the code
    assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(delay_code));

    // R3: no wrap past the top
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_valid && !hold && delay_code == code_t'(CODE_MAX) && !pd_err[ERR_W-1])
        |=> delay_code == code_t'(CODE_MAX));

    // R3: no wrap past the bottom
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_valid && !hold && delay_code == '0 && pd_err[ERR_W-1]) |=> delay_code == '0);

    // R7: a strobe with an update shows the new code on the bus
    assert_strobe_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> ctrl_bus == delay_code);
endmodule

// File: tb/dll_ctrl_bench.sv
module dll_ctrl_bench;

    typedef struct {
        int    code;
        int    bus;
        bit    lock;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_valid = 1'b0;
    logic [7:0] pd_err = '0;
    logic       hold = 1'b0;
    logic       bus_strobe = 1'b0;
    logic [8:0] delay_code;
    logic [8:0] ctrl_bus;
    logic       locked;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    exp_t q[$];

    int m_code = 256, m_bus = 256, m_near = 0, m_far = 0;
    bit m_lock = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dll_ctrl u_dll_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_valid  (pd_valid),
        .pd_err    (pd_err),
        .hold      (hold),
        .bus_strobe(bus_strobe),
        .delay_code(delay_code),
        .ctrl_bus  (ctrl_bus),
        .locked    (locked)
    );

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic push(input string tag);
        exp_t it;
        it.code = m_code; it.bus = m_bus; it.lock = m_lock; it.tag = tag;
        q.push_back(it);
    endtask

    // R1: synchronous reset cycle
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; pd_valid = 1'b0; hold = 1'b0; bus_strobe = 1'b0; pd_err = '0;
        m_code = 256; m_bus = 256; m_lock = 1'b0; m_near = 0; m_far = 0;
        push(tag);
    endtask

    task automatic drive(input bit v, input bit h, input bit s, input int e, input string tag);
        int st, sum;
        @(negedge clk);
        rst_n = 1'b1; pd_valid = v; hold = h; bus_strobe = s; pd_err = 8'(e);
        if (v && !h) begin
            st  = (e > 8) ? 8 : ((e < -8) ? -8 : e);
            sum = m_code + st;
            m_code = (sum > 511) ? 511 : ((sum < 0) ? 0 : sum);
        end
        if (s) m_bus = m_code;
        if (v) begin
            if (iabs(e) <= 1) begin
                m_near++;
                if (m_near >= 16) m_lock = 1'b1;
            end else m_near = 0;
            if (iabs(e) > 4) begin
                m_far++;
                if (m_far >= 4) m_lock = 1'b0;
            end else m_far = 0;
        end
        push(tag);
    endtask

    // monitor: pops the item pushed for this edge and compares
    always @(posedge clk) begin
        exp_t it;
        #2;
        if (q.size() > 0) begin
            it = q.pop_front();
            n_checks++;
            if (int'(delay_code) != it.code || int'(ctrl_bus) != it.bus || locked != it.lock) begin
                n_fail++;
                $display("FAIL %s: code=%0d bus=%0d lock=%0b expected code=%0d bus=%0d lock=%0b",
                         it.tag, delay_code, ctrl_bus, locked, it.code, it.bus, it.lock);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset");
        do_reset("R1 reset");
        // R4: samples without valid leave the code alone
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 60 - i * 70, "R4 idle");
        // R2: in-range and clamped steps
        drive(1, 0, 0, 3, "R2 step +3");
        drive(1, 0, 0, -5, "R2 step -5");
        drive(1, 0, 0, 100, "R2 clamp +8");
        drive(1, 0, 0, -128, "R2 clamp -8");
        drive(1, 0, 0, 0, "R2 zero");
        // R6: bus only on strobe
        drive(1, 0, 0, 7, "R6 no strobe");
        drive(0, 0, 1, 0, "R6 idle strobe");
        drive(1, 0, 0, -2, "R6 bus kept");
        // R7: strobe in the update cycle
        drive(1, 0, 1, 6, "R7 strobe with update");
        drive(1, 0, 1, -8, "R7 strobe with update");
        // R3: saturate high then low
        for (int i = 0; i < 40; i++) drive(1, 0, 0, 127, "R3 top");
        drive(1, 0, 1, 1, "R3 top hold");
        for (int i = 0; i < 70; i++) drive(1, 0, 0, -100, "R3 bottom");
        drive(1, 0, 1, -1, "R3 bottom hold");
        drive(1, 0, 0, 5, "R3 leave bottom");
        // R5: hold freezes and resumes
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 50, "R5 hold");
        drive(1, 1, 1, -50, "R5 hold strobe");
        drive(1, 0, 0, 4, "R5 resume");
        // R8: lock acquisition with a restart
        for (int i = 0; i < 10; i++) drive(1, 0, 0, (i % 2) ? 1 : -1, "R8 near");
        drive(1, 0, 0, 2, "R8 restart");
        for (int i = 0; i < 15; i++) drive(1, 0, 0, (i % 3) - 1, "R8 near 15");
        drive(0, 0, 0, 90, "R8 gap");
        drive(1, 0, 0, 0, "R8 16th");
        drive(1, 0, 0, 3, "R8 stay locked");
        // R9: loss with a restart
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 20, "R9 far");
        drive(1, 0, 0, -4, "R9 restart");
        for (int i = 0; i < 3; i++) drive(1, 0, 0, -9, "R9 far 3");
        drive(1, 0, 0, 5, "R9 4th");
        // R10: counting during hold
        for (int i = 0; i < 16; i++) drive(1, 1, 0, 0, "R10 acquire in hold");
        for (int i = 0; i < 4; i++) drive(1, 1, 0, -30, "R10 lose in hold");
        drive(1, 0, 1, 2, "R10 after hold");
        do_reset("R1 reset again");
        drive(0, 0, 0, 0, "R1 after reset");
        @(negedge clk);
        pd_valid = 1'b0; bus_strobe = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule